// File: doc/BRIEF.md
# Pulsed Byte-Program Sequencer

This block sits on the host side of a byte-wide flash device that is programmed through a command register. A request names one target address and one data byte. The sequencer then runs a closed loop of program pulses and read-back checks until the byte holds the wanted value or the pulse budget is spent. It does not drive the device pins itself. It hands each bus cycle (a write or a read, with address and data) to a bus master over a request/acknowledge handshake. The master returns read data together with the acknowledge.

Each attempt is a fixed chain of states. `ST_SETUP` writes the program set-up command 40H. `ST_LOAD` writes the data byte to the target address, and that write applies the pulse. `ST_PULSE` waits `PULSE_CYC` cycles. `ST_VERIFY` writes C0H, which stops programming and enters verify. `ST_RECOVER` waits `RECOV_CYC` cycles. `ST_READBACK` reads the target address.

The transitions out of `ST_READBACK` are:
- A match goes to `ST_EXIT`.
- A mismatch with pulses left goes back to `ST_SETUP`.
- A mismatch after the last allowed pulse goes to `ST_EXIT` and marks the operation as failed.

`ST_EXIT` always writes 00H to return the device to array-read mode. `ST_FINISH` then raises `done_o` for one cycle, and `fail_o` rises with it on a failure. The sequencer then goes back to `ST_IDLE`. `ST_IDLE` leaves only on a start strobe while the supply-ready input is high.

Top module: `byte_prog_seq`

## Requirements
- R1: In `ST_IDLE`, a start strobe is accepted only while `vpp_ready_i` is high. It latches `addr_i` and `data_i`. A strobe while `vpp_ready_i` is low produces no bus request and no `done_o`.
- R2: While `req_valid_o` is high and `req_ack_i` is low, `req_valid_o`, `req_write_o`, `req_addr_o` and `req_wdata_o` stay unchanged into the next cycle.
- R3: Every attempt issues, in this order, four requests to the latched address: a write of 40H, a write of the latched data byte, a write of C0H, and a read (`req_write_o` = 0).
- R4: The C0H write request first appears exactly `PULSE_CYC` cycles after the clock edge at which the data write is acknowledged.
- R5: The read request first appears exactly `RECOV_CYC` cycles after the clock edge at which the C0H write is acknowledged.
- R6: If the acknowledged read data equals the latched byte, the operation passes with no further pulses. Otherwise another attempt starts, until `MAX_PULSES` data writes have been issued. A mismatch on the last of those fails the operation.
- R7: Whether it passes or fails, the last request of an operation is a write of 00H to the latched address.
- R8: `done_o` is high for exactly one cycle: the cycle after the 00H write is acknowledged. `fail_o` is high only together with `done_o`, and only when the operation failed.
- R9: Start strobes and changes on `addr_i`/`data_i` while the sequencer is busy have no effect on the running operation.
- R10: During and right after reset, `req_valid_o`, `done_o` and `fail_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one byte-program operation |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | DATA_W | Byte value to program |
| vpp_ready_i | input | 1 | High when the programming supply is ready |
| req_valid_o | output | 1 | Bus request pending |
| req_write_o | output | 1 | 1 = write cycle, 0 = read cycle |
| req_addr_o | output | ADDR_W | Bus request address |
| req_wdata_o | output | DATA_W | Write data (command or byte) |
| req_ack_i | input | 1 | Bus master completes the pending request |
| req_rdata_i | input | DATA_W | Read data, valid with `req_ack_i` on a read |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Failure flag, valid with `done_o` |

## Verification
The assertions check these behaviours on every cycle:
- a pending request holds steady until it is acknowledged;
- a start strobe without supply ready leaves the sequencer idle;
- the latched address does not move while busy;
- the wait counter stays below its limit, and the pulse tally never passes its cap;
- `done_o` lasts one cycle, follows an acknowledged 00H write, and carries `fail_o` only with it.

Other behaviours can only be shown by the bench's sweep over how many pulses the byte needs, from one to beyond the cap, with varied acknowledge latency. These are the command order of each attempt, the exact pulse and recovery gaps, the pass/fail decision at the cap boundary, and the closing read-array write.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_PULSE,
        ST_VERIFY,
        ST_RECOVER,
        ST_READBACK,
        ST_EXIT,
        ST_FINISH
    } seq_state_t;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PROG_VERIFY = 8'hC0;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'h00;

endpackage

// File: rtl/prog_wait_timer.sv
module prog_wait_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == limit_i - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4 / R5: a wait never runs past its limit
    a_r4_timer_bound : assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));

    // R5: the counter starts from zero on every new wait
    a_r5_timer_fresh : assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |=> (cnt_q == '0));

endmodule

// File: rtl/prog_pulse_tally.sv
module prog_pulse_tally #(
    parameter int MAX_PULSES = 25,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic incr_i,
    output logic at_cap_o
);

    logic [CNT_W-1:0] count_q;

    assign at_cap_o = (count_q == CNT_W'(MAX_PULSES));

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            count_q <= '0;
        end else if (incr_i && !at_cap_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R6: the pulse tally never exceeds the cap
    a_r6_tally_cap : assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(MAX_PULSES));

    // R6: each applied pulse is counted once
    a_r6_tally_step : assert property (@(posedge clk) disable iff (!rst_n)
        (incr_i && !clear_i && !at_cap_o) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 2500,
    parameter int RECOV_CYC  = 1500,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              vpp_ready_i,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              req_ack_i,
    input  logic [DATA_W-1:0] req_rdata_i,
    output logic              done_o,
    output logic              fail_o
);

    localparam int TMR_MAX = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              fail_q, fail_d;

    logic              accept;
    logic              tmr_run, tmr_expired;
    logic [TMR_W-1:0]  tmr_limit;
    logic              tally_clear, tally_incr, tally_cap;
    logic              byte_match;

    assign accept     = (state_q == ST_IDLE) && start_i && vpp_ready_i;
    assign byte_match = (req_rdata_i == data_q);

    // wait timer shared by pulse and recovery states
    assign tmr_run   = (state_q == ST_PULSE) || (state_q == ST_RECOVER);
    assign tmr_limit = (state_q == ST_PULSE) ? TMR_W'(PULSE_CYC) : TMR_W'(RECOV_CYC);

    prog_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (tmr_run),
        .limit_i  (tmr_limit),
        .expired_o(tmr_expired)
    );

    assign tally_clear = accept;
    assign tally_incr  = (state_q == ST_LOAD) && req_ack_i;

    prog_pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tally_clear),
        .incr_i  (tally_incr),
        .at_cap_o(tally_cap)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SETUP;
                    fail_d  = 1'b0;
                end
            end
            ST_SETUP:    if (req_ack_i)   state_d = ST_LOAD;
            ST_LOAD:     if (req_ack_i)   state_d = ST_PULSE;
            ST_PULSE:    if (tmr_expired) state_d = ST_VERIFY;
            ST_VERIFY:   if (req_ack_i)   state_d = ST_RECOVER;
            ST_RECOVER:  if (tmr_expired) state_d = ST_READBACK;
            ST_READBACK: begin
                if (req_ack_i) begin
                    if (byte_match) begin
                        state_d = ST_EXIT;
                        fail_d  = 1'b0;
                    end else if (tally_cap) begin
                        state_d = ST_EXIT;
                        fail_d  = 1'b1;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_EXIT:     if (req_ack_i)   state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
            if (accept) begin
                addr_q <= addr_i;
                data_q <= data_i;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_valid_o = 1'b0;
        req_write_o = 1'b1;
        req_addr_o  = addr_q;
        req_wdata_o = '0;
        done_o      = 1'b0;
        fail_o      = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                req_valid_o = 1'b1;
                req_wdata_o = DATA_W'(CMD_PROG_SETUP);
            end
            ST_LOAD: begin
                req_valid_o = 1'b1;
                req_wdata_o = data_q;
            end
            ST_VERIFY: begin
                req_valid_o = 1'b1;
                req_wdata_o = DATA_W'(CMD_PROG_VERIFY);
            end
            ST_READBACK: begin
                req_valid_o = 1'b1;
                req_write_o = 1'b0;
            end
            ST_EXIT: begin
                req_valid_o = 1'b1;
                req_wdata_o = DATA_W'(CMD_READ_ARRAY);
            end
            ST_FINISH: begin
                done_o = 1'b1;
                fail_o = fail_q;
            end
            default: ;
        endcase
    end

    // R1: no supply-ready, no departure from idle
    a_r1_start_gated : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && !vpp_ready_i) |=> (state_q == ST_IDLE));

    // R2: a pending request holds until acknowledged
    a_r2_req_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_write_o)
                                         && $stable(req_addr_o) && $stable(req_wdata_o)));

    // R8: done is a single-cycle pulse
    a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: fail only alongside done
    a_r8_fail_with_done : assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R7 / R8: done follows an acknowledged read-array write
    a_r7_exit_before_done : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ack_i && req_write_o && req_wdata_o == '0 && state_q == ST_EXIT)
        |=> done_o);

    // R9: the latched target does not move while busy
    a_r9_busy_latch : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(req_addr_o));

endmodule

// File: tb/byte_prog_seq_bench.sv
`timescale 1ns/1ps
module byte_prog_seq_bench;

    localparam int AW    = 12;
    localparam int DW    = 8;
    localparam int PULSE = 4;
    localparam int RECOV = 3;
    localparam int MAXP  = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic          ready = 1'b0;
    logic          ack = 1'b0;
    logic [DW-1:0] rdata = '0;
    logic          req_valid, req_write, done, fail;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;

    // bus master / flash model state
    int            lat = 0;
    int            need = 1;
    int            pulses = 0;
    logic [DW-1:0] cur_data = '0;
    int            nlog = 0;
    bit            log_w   [128];
    logic [AW-1:0] log_a   [128];
    logic [DW-1:0] log_d   [128];
    int            log_seen[128];
    int            log_ack [128];

    // done monitor
    int ndone = 0;
    bit last_fail = 1'b0;
    int done_cyc = 0;
    bit prev_done = 1'b0;
    int fail_pulses = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    byte_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PULSE), .RECOV_CYC(RECOV), .MAX_PULSES(MAXP)
    ) u_byte_prog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .data_i(data),
        .vpp_ready_i(ready), .req_valid_o(req_valid), .req_write_o(req_write),
        .req_addr_o(req_addr), .req_wdata_o(req_wdata), .req_ack_i(ack),
        .req_rdata_i(rdata), .done_o(done), .fail_o(fail)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // responder: acknowledges after lat waiting negedges
    initial begin
        int  waitc;
        bit  seen;
        int  seen_cyc;
        bit  h_w;
        logic [AW-1:0] h_a;
        logic [DW-1:0] h_d;
        waitc = 0; seen = 0; seen_cyc = 0; h_w = 0; h_a = '0; h_d = '0;
        forever begin
            @(negedge clk);
            if (ack) begin
                ack = 1'b0; waitc = 0; seen = 0;
            end else if (req_valid && rst_n) begin
                if (!seen) begin
                    seen = 1; seen_cyc = cyc;
                    h_w = req_write; h_a = req_addr; h_d = req_wdata;
                end else begin
                    // R2: request held until acknowledged
                    chk(h_w == req_write && h_a == req_addr && h_d == req_wdata,
                        "R2 hold", {req_write, req_addr, req_wdata}, {h_w, h_a, h_d});
                end
                if (waitc == lat) begin
                    if (nlog < 128) begin
                        log_w[nlog] = req_write; log_a[nlog] = req_addr;
                        log_d[nlog] = req_wdata; log_seen[nlog] = seen_cyc;
                        log_ack[nlog] = cyc;
                        if (req_write && nlog > 0 && log_w[nlog-1] && log_d[nlog-1] == 8'h40)
                            pulses++;
                        nlog++;
                    end
                    rdata = (pulses >= need) ? cur_data : (cur_data ^ 8'h5A);
                    ack = 1'b1;
                end else begin
                    waitc++;
                end
            end
        end
    end

    // done monitor
    initial begin
        forever begin
            @(negedge clk);
            if (fail && !done) fail_pulses++;
            if (done) begin
                ndone++; last_fail = fail; done_cyc = cyc;
                chk(!prev_done, "R8 done single cycle", 1, 0);
            end
            prev_done = done;
        end
    end

    task automatic run_one(input int n, input int l, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int  k, base, d0, guard;
        bit  pass;
        nlog = 0; pulses = 0; need = n; lat = l; cur_data = d;
        d0 = ndone;
        @(negedge clk);
        ready = 1'b1; addr = a; data = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        // R9: strobe with different operands while busy
        addr = a ^ 12'h0F1; data = d ^ 8'h33; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (ndone == d0 && guard < 4000) begin
            @(negedge clk); guard++;
        end
        chk(guard < 4000, "R8 completion reached", guard, 0);
        repeat (4) @(negedge clk);
        chk(ndone == d0 + 1, "R8 one done per operation", ndone - d0, 1);

        k    = (n <= MAXP) ? n : MAXP;
        pass = (n <= MAXP);
        chk(nlog == 4 * k + 1, "R6 request count", nlog, 4 * k + 1);
        for (int i = 0; i < k; i++) begin
            base = 4 * i;
            if (base + 3 < nlog) begin
                chk(log_w[base] && log_d[base] == 8'h40 && log_a[base] == a, "R3 setup write",
                    {log_w[base], log_a[base], log_d[base]}, {1'b1, a, 8'h40});
                chk(log_w[base+1] && log_d[base+1] == d && log_a[base+1] == a, "R9 data write",
                    {log_w[base+1], log_a[base+1], log_d[base+1]}, {1'b1, a, d});
                chk(log_w[base+2] && log_d[base+2] == 8'hC0, "R3 verify command",
                    {log_w[base+2], log_d[base+2]}, {1'b1, 8'hC0});
                chk(!log_w[base+3] && log_a[base+3] == a, "R3 read-back",
                    {log_w[base+3], log_a[base+3]}, {1'b0, a});
                chk(log_seen[base+2] - log_ack[base+1] == PULSE + 1, "R4 pulse gap",
                    log_seen[base+2] - log_ack[base+1] - 1, PULSE);
                chk(log_seen[base+3] - log_ack[base+2] == RECOV + 1, "R5 recovery gap",
                    log_seen[base+3] - log_ack[base+2] - 1, RECOV);
            end
        end
        if (nlog > 0) begin
            chk(log_w[nlog-1] && log_d[nlog-1] == 8'h00 && log_a[nlog-1] == a, "R7 read-array exit",
                {log_w[nlog-1], log_d[nlog-1]}, {1'b1, 8'h00});
            chk(done_cyc - log_ack[nlog-1] == 1, "R8 done timing",
                done_cyc - log_ack[nlog-1], 1);
        end
        chk(last_fail == !pass, "R6 pass/fail outcome", last_fail, !pass);
        chk(fail_pulses == 0, "R8 fail only with done", fail_pulses, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!req_valid && !done && !fail, "R10 reset outputs", {req_valid, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !done && !fail, "R10 after reset", {req_valid, done, fail}, 0);

        // R1: start without supply-ready is ignored
        ready = 1'b0; addr = 12'h123; data = 8'hA5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        chk(nlog == 0 && !req_valid, "R1 gated start, no request", nlog, 0);
        chk(ndone == 0, "R1 gated start, no done", ndone, 0);

        // sweep pulses needed from 1 to beyond the cap
        for (int n = 1; n <= MAXP + 1; n++) begin
            run_one(n, n % 3, AW'(12'h0A0 + n * 37), DW'(8'h11 * (n % 15) + n));
        end
        // boundary: fail with slow acknowledge, pass at first pulse with zero latency
        run_one(MAXP + 3, 2, 12'hFFF, 8'h00);
        run_one(1, 0, 12'h000, 8'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule